// File: doc/BRIEF.md
# One-Shot Edge-Aligned Pulse Timer

This block is an up-counting time base paired with up to four pulse outputs that run for exactly one period and then stop. Software writes the period and the per-output duty values, then writes a 1 to the enable bit. The mode field must select the one-shot mode for that write to take effect. All outputs with a non-zero duty go active together. Each output drops when the timer reaches its own duty value, or at the latest when the timer reaches the period.

When the timer reaches the period, several things happen on the next clock edge. The timer returns to zero, the enable bit clears itself, and a one-cycle interrupt pulse appears. The outputs are edge-aligned only: every pulse starts at timer value zero. Writing the enable bit to 1 again starts a fresh pulse from zero. Writing it to 0 while a pulse runs aborts the pulse without an interrupt.

The block has no streaming data path. All pins are plain control and status signals. The period and duty inputs are compared live on every cycle, so they should be held steady while a pulse runs.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset the enable status is 0, the timer count is 0, all four outputs are inactive and the interrupt is low.
- R2: A write strobe carrying 1 while the block is idle and the mode field equals binary 10 sets the enable status in the next cycle. In that cycle the timer reads 0 and every output whose duty is non-zero is active, provided the period is non-zero.
- R3: An enable write carrying 1 while the mode field is not binary 10 is ignored: the enable status stays 0 and the timer stays 0.
- R4: While enabled, the timer advances by exactly one per clock starting from 0. While the enable is clear, the timer holds at 0.
- R5: An output is active in the cycles where the timer value is below both its duty and the period. It therefore gives min(duty, period) active cycles, ending in the cycle where the timer equals its duty.
- R6: An output with a duty value of 0 is never active during the pulse.
- R7: In the cycle where the timer equals the period, all outputs are inactive. On the following clock the timer returns to 0 and the enable status clears, so the enable stays high for period+1 cycles.
- R8: The interrupt is high for exactly one cycle: the cycle after the period match. It is never high while the pulse runs.
- R9: After the enable has cleared itself, a new enable write of 1 starts another pulse from timer value 0 with the same timing.
- R10: An enable write carrying 0 while running clears the enable and the timer in the next cycle. The outputs go inactive and no interrupt is raised.
- R11: An enable write carrying 1 while already running has no effect: the timer keeps counting without restarting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Time base mode; binary 10 selects one-shot |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| period_val | input | 15 | Period compare value |
| duty_val | input | 4x15 | Duty compare value per output, packed |
| pin_active | output | 4 | Output active state, one bit per output |
| tmr_count | output | 15 | Current timer value |
| en_status | output | 1 | Enable bit as it currently stands |
| irq_pulse | output | 1 | One-cycle end-of-pulse interrupt |

## Verification
Several rules are checked on every clock cycle:
- the timer either steps by one or sits at zero;
- a period match always leads to a cleared enable together with an interrupt;
- the interrupt never lasts two cycles;
- no output is active without the enable;
- every output is off after a period match.

Other behaviour is shown only by the bench's scenarios:
- the exact number of active cycles per output across different duty and period combinations;
- the ignored enable write under a wrong mode;
- the abort without an interrupt;
- the non-restarting second write;
- back-to-back restarts from zero.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam logic [1:0] ONESHOT_MODE = 2'b10;

  typedef enum logic [1:0] {
    CTL_HOLD  = 2'b00,
    CTL_START = 2'b01,
    CTL_STOP  = 2'b10,
    CTL_MATCH = 2'b11
  } ctl_evt_e;
endpackage

// File: rtl/spt_enable_ctl.sv
module spt_enable_ctl
  import spt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       en_wr,
  input  logic       en_wdata,
  input  logic       pmatch,
  output logic       en_q,
  output logic       irq_q,
  output logic       start_fire,
  output logic       run
);
  ctl_evt_e evt;

  // Event priority: a period match wins, then an abort write, then a start.
  always_comb begin
    if (pmatch)                                     evt = CTL_MATCH;
    else if (en_wr && !en_wdata && en_q)            evt = CTL_STOP;
    else if (en_wr && en_wdata && !en_q &&
             mode_sel == ONESHOT_MODE)              evt = CTL_START;
    else                                            evt = CTL_HOLD;
  end

  assign start_fire = (evt == CTL_START);
  assign run        = en_q && (evt != CTL_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= (evt == CTL_MATCH);
      case (evt)
        CTL_START: en_q <= 1'b1;
        CTL_STOP,
        CTL_MATCH: en_q <= 1'b0;
        default:   en_q <= en_q;
      endcase
    end
  end

  assert_match_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pmatch |=> (!en_q && irq_q));
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  assert_idle_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !start_fire) |=> !en_q);
endmodule

// File: rtl/spt_timebase.sv
module spt_timebase #(
  parameter int TW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          en_q,
  input  logic [TW-1:0] period_val,
  output logic [TW-1:0] tmr_q,
  output logic [TW-1:0] tmr_nxt,
  output logic          pmatch
);
  assign pmatch  = en_q && (tmr_q == period_val);
  assign tmr_nxt = tmr_q + TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmr_q <= '0;
    else if (run && !pmatch)   tmr_q <= tmr_nxt;
    else                       tmr_q <= '0;
  end

  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tmr_q == '0));
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pmatch) |=> (tmr_q == TW'($past(tmr_q) + TW'(1))));
  assert_match_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pmatch |=> (tmr_q == '0));
endmodule

// File: rtl/spt_channel.sv
module spt_channel #(
  parameter int TW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_fire,
  input  logic          run,
  input  logic          en_q,
  input  logic          pmatch,
  input  logic [TW-1:0] tmr_nxt,
  input  logic [TW-1:0] duty_val,
  input  logic [TW-1:0] period_val,
  output logic          pin_q
);
  logic keep_on;

  // Stays active only if the next count reaches neither its duty nor the period.
  assign keep_on = run && !pmatch && pin_q &&
                   (tmr_nxt != duty_val) && (tmr_nxt != period_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pin_q <= 1'b0;
    else if (start_fire) pin_q <= (duty_val != '0) && (period_val != '0);
    else                 pin_q <= keep_on;
  end

  assert_pin_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q |-> en_q);
  assert_off_after_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pmatch |=> !pin_q);
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer #(
  parameter int NCH = 4,
  parameter int TW  = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_sel,
  input  logic                    en_wr,
  input  logic                    en_wdata,
  input  logic [TW-1:0]           period_val,
  input  logic [NCH-1:0][TW-1:0]  duty_val,
  output logic [NCH-1:0]          pin_active,
  output logic [TW-1:0]           tmr_count,
  output logic                    en_status,
  output logic                    irq_pulse
);
  logic          en_q, irq_q, start_fire, run, pmatch;
  logic [TW-1:0] tmr_q, tmr_nxt;

  spt_enable_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .en_wr(en_wr),
    .en_wdata(en_wdata), .pmatch(pmatch), .en_q(en_q), .irq_q(irq_q),
    .start_fire(start_fire), .run(run)
  );

  spt_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .en_q(en_q),
    .period_val(period_val), .tmr_q(tmr_q), .tmr_nxt(tmr_nxt), .pmatch(pmatch)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    spt_channel #(.TW(TW)) u_ch (
      .clk(clk), .rst_n(rst_n), .start_fire(start_fire), .run(run),
      .en_q(en_q), .pmatch(pmatch), .tmr_nxt(tmr_nxt),
      .duty_val(duty_val[g]), .period_val(period_val), .pin_q(pin_active[g])
    );
  end

  assign tmr_count = tmr_q;
  assign en_status = en_q;
  assign irq_pulse = irq_q;

  assert_no_irq_while_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !en_status);
  assert_pins_below_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_active != '0) |-> (tmr_count < period_val));
endmodule

// File: tb/oneshot_pulse_timer_test.sv
module oneshot_pulse_timer_test;
  localparam int NCH = 4;
  localparam int TW  = 15;
  localparam int NV  = 5;

  // period, duty0..3, expected active cycles out0..3
  localparam int VEC [NV][9] = '{
    '{10, 0, 3, 10, 20,   0, 3, 10, 10},
    '{ 5, 1, 5,  4,  2,   1, 5,  4,  2},
    '{ 0, 3, 0,  1,  7,   0, 0,  0,  0},
    '{ 1, 1, 2,  0,  1,   1, 1,  0,  1},
    '{30, 29, 31, 15, 100, 29, 30, 15, 30}
  };

  logic                   clk = 0;
  logic                   rst_n = 0;
  logic [1:0]             mode_sel = 2'b10;
  logic                   en_wr = 0, en_wdata = 0;
  logic [TW-1:0]          period_val = '0;
  logic [NCH-1:0][TW-1:0] duty_val = '0;
  logic [NCH-1:0]         pin_active;
  logic [TW-1:0]          tmr_count;
  logic                   en_status, irq_pulse;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  oneshot_pulse_timer uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .en_wr(en_wr),
    .en_wdata(en_wdata), .period_val(period_val), .duty_val(duty_val),
    .pin_active(pin_active), .tmr_count(tmr_count), .en_status(en_status),
    .irq_pulse(irq_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic write_en(input bit v);
    @(negedge clk);
    en_wr = 1; en_wdata = v;
    @(negedge clk);
    en_wr = 0;
  endtask

  task automatic run_vec(input int p, input int d0, input int d1, input int d2,
                         input int d3, input int e0, input int e1, input int e2,
                         input int e3);
    int cnt [NCH];
    int n, irq_seen;
    int exp_a [NCH];
    exp_a = '{e0, e1, e2, e3};
    cnt = '{0, 0, 0, 0};
    n = 0; irq_seen = 0;
    period_val = TW'(p);
    duty_val = {TW'(d3), TW'(d2), TW'(d1), TW'(d0)};
    mode_sel = 2'b10;
    write_en(1'b1);
    check(en_status == 1'b1, "R2 enable set", int'(en_status), 1);
    check(tmr_count == '0, "R9 start from zero", int'(tmr_count), 0);
    while (en_status && n < 40000) begin
      check(tmr_count == TW'(n), "R4 count step", int'(tmr_count), n);
      if (irq_pulse) irq_seen++;
      for (int i = 0; i < NCH; i++) if (pin_active[i]) cnt[i]++;
      n++;
      @(negedge clk);
    end
    check(irq_seen == 0, "R8 no irq while running", irq_seen, 0);
    check(n == p + 1, "R7 enable cycles", n, p + 1);
    check(irq_pulse == 1'b1, "R8 irq after match", int'(irq_pulse), 1);
    check(tmr_count == '0, "R7 timer cleared", int'(tmr_count), 0);
    for (int i = 0; i < NCH; i++)
      check(cnt[i] == exp_a[i], (exp_a[i] == 0) ? "R6 zero duty idle" : "R5 active count",
            cnt[i], exp_a[i]);
    @(negedge clk);
    check(irq_pulse == 1'b0, "R8 irq one cycle", int'(irq_pulse), 0);
    check(pin_active == '0, "R7 pins off", int'(pin_active), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(en_status == 0 && tmr_count == '0 && pin_active == '0 && irq_pulse == 0,
          "R1 reset state", int'(en_status), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
              VEC[v][5], VEC[v][6], VEC[v][7], VEC[v][8]);

    // R9: back-to-back restart after self-clear
    run_vec(4, 2, 4, 0, 9, 2, 4, 0, 4);

    // R3: wrong mode ignores enable write
    mode_sel = 2'b01;
    period_val = 15'd8;
    @(negedge clk);
    en_wr = 1; en_wdata = 1;
    @(negedge clk);
    en_wr = 0;
    check(en_status == 1'b0, "R3 mode ignore enable", int'(en_status), 0);
    @(negedge clk);
    check(tmr_count == '0, "R3 timer stays zero", int'(tmr_count), 0);
    check(tmr_count == '0, "R4 hold at zero when idle", int'(tmr_count), 0);

    // R10: abort mid-pulse
    mode_sel = 2'b10;
    period_val = 15'd50;
    duty_val = {15'd40, 15'd40, 15'd40, 15'd40};
    write_en(1'b1);
    repeat (5) @(negedge clk);
    check(tmr_count == 15'd5, "R4 count before abort", int'(tmr_count), 5);
    write_en(1'b0);
    check(en_status == 1'b0, "R10 abort clears enable", int'(en_status), 0);
    check(tmr_count == '0, "R10 abort clears timer", int'(tmr_count), 0);
    check(pin_active == '0, "R10 abort pins off", int'(pin_active), 0);
    check(irq_pulse == 1'b0, "R10 no irq on abort", int'(irq_pulse), 0);
    @(negedge clk);
    check(irq_pulse == 1'b0, "R10 no late irq", int'(irq_pulse), 0);

    // R11: second enable write while running does not restart
    period_val = 15'd20;
    duty_val = {15'd6, 15'd6, 15'd6, 15'd6};
    write_en(1'b1);
    repeat (3) @(negedge clk);
    en_wr = 1; en_wdata = 1;
    @(negedge clk);
    en_wr = 0;
    check(tmr_count == 15'd4, "R11 no restart", int'(tmr_count), 4);
    check(en_status == 1'b1, "R11 still enabled", int'(en_status), 1);
    while (en_status) @(negedge clk);
    check(irq_pulse == 1'b1, "R11 ends with irq", int'(irq_pulse), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule